// File: doc/BRIEF.md
# Register Write-Pending Tracker

This block tells the decode stage of a short in-order pipeline whether a source operand still waits on an older instruction that has not yet written its result. It keeps one small in-flight counter for every architectural register. It does not hold a list of destination indices. A lookup therefore reads one counter directly and does not compare against every entry in a queue.

Decode uses the insert port only when it really dispatches an instruction into execute. That port carries the instruction's optional destination. Commit uses the remove port and names the destination being retired. Two search ports answer combinationally in the same cycle, one port for each source operand, so checking both operands causes no conflict.

A remove that arrives in the same cycle as a search is applied before the search. An instruction that depends on the committing one can therefore issue at once. Register 0 is never written, so it never reports a hazard.

Top module: `regdep_tracker`

## Requirements
- R1: After reset every counter is zero, so no search of any register returns busy.
- R2: A valid insert naming register r (r not 0) adds one to r's counter at the next rising edge, and a later search of r then returns busy.
- R3: A search returns busy only when its valid bit is 1 and the pending count of its register is non-zero. A search with valid 0 always returns 0.
- R4: The two search ports are independent. Both give correct answers for different registers in the same cycle.
- R5: A valid remove in the same cycle as a search is subtracted before the search. If the removed write was the last pending one for that register, the search returns 0 in that cycle.
- R6: When several writes to one register are pending, busy stays set until every one of them has been removed.
- R7: An insert with valid 0 leaves every counter unchanged.
- R8: A remove with valid 0 leaves every counter unchanged.
- R9: If insert and remove name the same register in one cycle, its counter keeps its value. If they name different registers, both updates take effect.
- R10: Counters hold up to MAX_INFLIGHT+1, which is 3 with the default MAX_INFLIGHT of 2. An increment at that maximum or a decrement at zero is flagged by an assertion.
- R11: Inserts to register 0 are ignored, and a search of register 0 always returns 0.
- R12: Search outputs are combinational. They follow a change of the search index within the same cycle, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_vld | input | 1 | Dispatch carries a destination |
| ins_reg | input | IDX_W | Destination index of the dispatched instruction |
| rem_vld | input | 1 | Commit carries a destination |
| rem_reg | input | IDX_W | Destination index of the committing instruction |
| srch_a_vld | input | 1 | First source operand is used |
| srch_a_reg | input | IDX_W | First source index |
| srch_a_busy | output | 1 | First source has a pending write |
| srch_b_vld | input | 1 | Second source operand is used |
| srch_b_reg | input | IDX_W | Second source index |
| srch_b_busy | output | 1 | Second source has a pending write |

## Verification
Search results are due in the same cycle as their stimulus, because they are combinational from the counters and the same-cycle remove. An insert or remove shows up in search results only from the cycle after its rising edge. The bench drives every input at the falling edge and samples the busy outputs 5 ns later, before the next rising edge. Each expected value therefore combines the counts left by earlier cycles with the remove of the current cycle, and never includes the insert of the current cycle.

// File: rtl/regdep_pkg.sv
package regdep_pkg;

  // Next value of an in-flight counter given one increment and one decrement
  function automatic int unsigned cnt_step(int unsigned cur, logic up, logic down);
    int unsigned r;
    r = cur;
    if (up && !down) r = cur + 1;
    else if (down && !up) r = cur - 1;
    return r;
  endfunction

  // Writes still pending once a same-cycle commit has been taken out
  function automatic int unsigned pending_after(int unsigned cur, logic leaving);
    return (leaving && cur != 0) ? cur - 1 : cur;
  endfunction

endpackage

// File: rtl/regdep_cell.sv
module regdep_cell #(
  parameter int CW      = 2,
  parameter int CNT_MAX = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] count
);
  import regdep_pkg::*;

  logic [CW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= CW'(cnt_step(int'(count_q), inc, dec));
  end

  assign count = count_q;

  a_r2_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec) |=> count_q == $past(count_q) + CW'(1));
  a_r9_same_reg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec) |=> $stable(count_q));
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !dec) |=> $stable(count_q));
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec) |-> count_q != CW'(CNT_MAX));
  a_r10_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc) |-> count_q != '0);

endmodule

// File: rtl/regdep_probe.sv
module regdep_probe #(
  parameter int NUM_REGS = 32,
  parameter int IDX_W    = 5,
  parameter int CW       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    cnt [NUM_REGS],
  input  logic             rem_vld,
  input  logic [IDX_W-1:0] rem_reg,
  input  logic             src_vld,
  input  logic [IDX_W-1:0] src_reg,
  output logic             busy
);
  import regdep_pkg::*;

  logic          leaving;
  logic [CW-1:0] raw_cnt;
  int unsigned   left_cnt;

  always_comb begin
    raw_cnt  = cnt[src_reg];
    leaving  = rem_vld && (rem_reg == src_reg);
    left_cnt = pending_after(int'(raw_cnt), leaving);
    busy     = src_vld && (src_reg != '0) && (left_cnt != 0);
  end

  a_r5_remove_first: assert property (@(posedge clk) disable iff (!rst_n)
    (src_vld && rem_vld && rem_reg == src_reg && raw_cnt == CW'(1)) |-> !busy);
  a_r3_invalid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !src_vld |-> !busy);

endmodule

// File: rtl/regdep_tracker.sv
module regdep_tracker #(
  parameter int NUM_REGS    = 32,
  parameter int MAX_INFLIGHT = 2,
  parameter int IDX_W       = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_vld,
  input  logic [IDX_W-1:0] ins_reg,
  input  logic             rem_vld,
  input  logic [IDX_W-1:0] rem_reg,
  input  logic             srch_a_vld,
  input  logic [IDX_W-1:0] srch_a_reg,
  output logic             srch_a_busy,
  input  logic             srch_b_vld,
  input  logic [IDX_W-1:0] srch_b_reg,
  output logic             srch_b_busy
);
  localparam int CNT_MAX   = MAX_INFLIGHT + 1;
  localparam int CW        = $clog2(CNT_MAX + 1);
  localparam int NUM_PORTS = 2;

  logic [CW-1:0]    cnt     [NUM_REGS];
  logic             inc_vec [NUM_REGS];
  logic             dec_vec [NUM_REGS];
  logic             p_vld   [NUM_PORTS];
  logic [IDX_W-1:0] p_reg   [NUM_PORTS];
  logic             p_busy  [NUM_PORTS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    if (g == 0) begin : g_hardzero
      assign inc_vec[g] = 1'b0;
      assign dec_vec[g] = 1'b0;
      assign cnt[g]     = '0;
    end else begin : g_counted
      assign inc_vec[g] = ins_vld && (ins_reg == IDX_W'(g));
      assign dec_vec[g] = rem_vld && (rem_reg == IDX_W'(g));
      regdep_cell #(.CW(CW), .CNT_MAX(CNT_MAX)) u_cell (
        .clk(clk), .rst_n(rst_n), .inc(inc_vec[g]), .dec(dec_vec[g]), .count(cnt[g]));
    end
  end

  assign p_vld[0] = srch_a_vld;
  assign p_reg[0] = srch_a_reg;
  assign p_vld[1] = srch_b_vld;
  assign p_reg[1] = srch_b_reg;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    regdep_probe #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .CW(CW)) u_probe (
      .clk(clk), .rst_n(rst_n), .cnt(cnt), .rem_vld(rem_vld), .rem_reg(rem_reg),
      .src_vld(p_vld[p]), .src_reg(p_reg[p]), .busy(p_busy[p]));
  end

  assign srch_a_busy = p_busy[0];
  assign srch_b_busy = p_busy[1];

  a_r2_insert_seen: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_vld && ins_reg != '0 && !(rem_vld && rem_reg == ins_reg)) |=>
    (!(srch_a_vld && srch_a_reg == $past(ins_reg) && !(rem_vld && rem_reg == srch_a_reg))
     || srch_a_busy));
  a_r11_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_a_reg == '0) |-> !srch_a_busy);
  a_r11_zero_idle_b: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_b_reg == '0) |-> !srch_b_busy);

endmodule

// File: tb/regdep_tracker_test.sv
module regdep_tracker_test;
  localparam int IDX_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ins_vld = 0, rem_vld = 0, srch_a_vld = 0, srch_b_vld = 0;
  logic [IDX_W-1:0] ins_reg = '0, rem_reg = '0, srch_a_reg = '0, srch_b_reg = '0;
  logic srch_a_busy, srch_b_busy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  regdep_tracker uut (
    .clk(clk), .rst_n(rst_n),
    .ins_vld(ins_vld), .ins_reg(ins_reg), .rem_vld(rem_vld), .rem_reg(rem_reg),
    .srch_a_vld(srch_a_vld), .srch_a_reg(srch_a_reg), .srch_a_busy(srch_a_busy),
    .srch_b_vld(srch_b_vld), .srch_b_reg(srch_b_reg), .srch_b_busy(srch_b_busy));

  // Vector layout: ins_vld,ins_reg,rem_vld,rem_reg,a_vld,a_reg,b_vld,b_reg,exp_a,exp_b
  function automatic logic [25:0] v(bit iv, int ir, bit rv, int rr, bit av, int ar,
                                    bit bv, int br, bit ea, bit eb);
    return {iv, 5'(ir), rv, 5'(rr), av, 5'(ar), bv, 5'(br), ea, eb};
  endfunction

  localparam int NV = 13;
  localparam logic [25:0] VEC [NV] = '{
    v(1, 5, 0, 0, 1, 5, 1, 6, 0, 0), // R2 insert r5; R1 still clear
    v(1, 5, 0, 0, 1, 5, 1, 0, 1, 0), // R2 busy, R11 r0 search, R6 second write to r5
    v(1, 7, 1, 5, 1, 5, 0, 7, 1, 0), // R6 one of two left, R3 invalid src
    v(0, 0, 1, 5, 1, 5, 1, 7, 0, 1), // R5 last remove seen same cycle, R4
    v(1, 0, 0, 0, 1, 5, 1, 7, 0, 1), // R11 insert to r0
    v(0, 0, 0, 0, 1, 0, 0, 7, 0, 0), // R11 r0 still idle, R3 valid=0
    v(1, 9, 1, 7, 1, 7, 1, 9, 0, 0), // R9 different regs both act, R5
    v(1, 9, 1, 9, 1, 9, 1, 9, 0, 0), // R9 same reg same cycle
    v(0, 0, 0, 0, 1, 9, 1, 9, 1, 1), // R9 count held at one
    v(0, 0, 0, 9, 1, 9, 1, 7, 1, 0), // R8 remove with valid 0
    v(0, 12, 0, 0, 1, 9, 1, 12, 1, 0), // R7 insert with valid 0
    v(0, 0, 1, 9, 1, 12, 1, 9, 0, 0), // R7 r12 untouched, R5
    v(0, 0, 0, 0, 1, 9, 1, 5, 0, 0)  // R8 r9 drained
  };

  task automatic check(bit act, bit exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic drive(bit iv, int ir, bit rv, int rr, bit av, int ar, bit bv, int br);
    @(negedge clk);
    ins_vld = iv; ins_reg = 5'(ir); rem_vld = rv; rem_reg = 5'(rr);
    srch_a_vld = av; srch_a_reg = 5'(ar); srch_b_vld = bv; srch_b_reg = 5'(br);
    #5;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: nothing pending after reset
    for (int r = 1; r < 32; r += 2) begin
      drive(0, 0, 0, 0, 1, r, 1, r - 1);
      check(srch_a_busy, 0, "R1 reset port a");
      check(srch_b_busy, 0, "R1 reset port b");
    end

    for (int i = 0; i < NV; i++) begin
      logic [25:0] e;
      e = VEC[i];
      drive(e[25], int'(e[24:20]), e[19], int'(e[18:14]), e[13], int'(e[12:8]),
            e[7], int'(e[6:2]));
      check(srch_a_busy, e[1], $sformatf("R4 table row %0d port a", i));
      check(srch_b_busy, e[0], $sformatf("R4 table row %0d port b", i));
    end

    // R10: fill r3 to the maximum of 3, then drain
    for (int k = 0; k < 3; k++) drive(1, 3, 0, 0, 1, 3, 0, 0);
    drive(0, 0, 1, 3, 1, 3, 0, 0);
    check(srch_a_busy, 1, "R10 three pending minus one");
    drive(0, 0, 1, 3, 1, 3, 0, 0);
    check(srch_a_busy, 1, "R10 two pending minus one");
    drive(0, 0, 1, 3, 1, 3, 1, 3);
    check(srch_a_busy, 0, "R6 last removal clears");
    drive(0, 0, 0, 0, 1, 3, 0, 0);
    check(srch_a_busy, 0, "R10 counter back at zero");

    // R12: combinational follow of the search index
    drive(1, 4, 0, 0, 1, 6, 0, 0);
    drive(0, 0, 0, 0, 1, 6, 0, 0);
    check(srch_a_busy, 0, "R12 idle register");
    srch_a_reg = 5'd4; #1;
    check(srch_a_busy, 1, "R12 same cycle index change");

    // R1: reset clears a pending write
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    #5;
    check(srch_a_busy, 0, "R1 reset clears pending");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule